// File: doc/BRIEF.md
# Auxiliary Interrupt Output Reference Counter

This block gathers interrupt sources that are steered to side outputs of a destination (critical or error lines, say) rather than to the prioritized main request. Those side outputs bypass priority thresholds, acknowledge and end-of-interrupt. Each source therefore only says whether it is asserting, and which destination and which side output it goes to. For every (destination, side output) pair, the block keeps a count of the sources that are asserting at that moment. The matching output is high while that count is non-zero.

The count moves only when a source changes its activity state. When a source goes from inactive to active, one is added to the slot it is routed to, and that slot is recorded. When the source goes from active to inactive, one is removed from the recorded slot. A level source is active while its request is high and it is not masked. An edge source is active for exactly the one cycle that follows a sampled rising edge, and then it clears itself. This makes an edge source a single pulse and never a stuck request.

Top module: `aux_irq_refcnt`

## Requirements
- R1: A synchronous active-high `rst` clears every count and every held route. `aux_irq` is all zero in the cycle after a reset edge.
- R2: Source i is active when `src_mask[i]` is 0 and one of these holds: `src_edge[i]`=0 (level mode) with `src_req[i]` high, or `src_edge[i]`=1 (edge mode) with `src_req[i]` high now and low at the previous clock edge. The previous-edge sample is 0 after reset.
- R3: A source that becomes active adds one to its slot. The slot's `aux_irq` bit rises on the clock edge where its count leaves zero.
- R4: A source that stops being active removes one from the slot it was counted in. The bit falls only on the edge where the count returns to zero.
- R5: While no source changes activity state, no count changes and `aux_irq` holds. This includes a level request held high over many cycles.
- R6: An edge-mode source that is alone on its slot drives that bit high for exactly one cycle per rising edge, even when its request stays high.
- R7: Setting the mask of an active source withdraws it, as in R4. A rising edge that arrives while the source is masked is discarded and does not fire after unmasking.
- R8: The route is captured when the source becomes active. A route change while the source is active neither moves its count nor redirects its later decrement.
- R9: The slot index is dst*N_OUT+out and equals the bit position in `aux_irq`. A source whose dst is N_DST or more, or whose out is N_OUT or more, adds to no slot.
- R10: Transitions of several sources in the same cycle are all counted. A count never exceeds N_SRC, and a decrement that would take it below zero is dropped.
- R11: Each `aux_irq` bit is a register that equals (count of its slot != 0) and changes only on the edge where a transition is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_req | input | N_SRC | Request level of each source |
| src_edge | input | N_SRC | Trigger mode per source: 1 edge, 0 level |
| src_mask | input | N_SRC | Mask per source: 1 masked |
| src_dst | input | N_SRC*DW | Destination index of source i at bits [i*DW +: DW] |
| src_out | input | N_SRC*OW | Side-output index of source i at bits [i*OW +: OW] |
| aux_irq | output | N_DST*N_OUT | Side-output line per slot, bit dst*N_OUT+out |

## Verification
The assertions assume that reset is held for at least two cycles, so that the reset edge itself never reads as a falling output. They also assume that the mode bit of an edge source stays at edge for the cycle after that source fires. The stimulus holds every reset for two or more cycles and changes mode bits only rarely. Routes, masks and requests are changed freely and at random, including while sources are active, so the captured-route and withdraw paths are exercised. The reference model in the bench keeps its own per-source history and slot counts.

// File: rtl/aux_refcnt_pkg.sv
package aux_refcnt_pkg;
  // Slot number of a (destination, side output) pair, -1 when out of range
  function automatic int slot_index(input int unsigned d, input int unsigned o,
                                    input int unsigned n_dst, input int unsigned n_out);
    if (d >= n_dst || o >= n_out) return -1;
    return int'(d * n_out + o);
  endfunction
endpackage

// File: rtl/aux_src_track.sv
module aux_src_track
  import aux_refcnt_pkg::*;
#(
  parameter int N_DST  = 3,
  parameter int N_OUT  = 2,
  parameter int DW     = 2,
  parameter int OW     = 1,
  parameter int N_SLOT = N_DST * N_OUT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              edge_mode,
  input  logic              mask,
  input  logic [DW-1:0]     dst,
  input  logic [OW-1:0]     outi,
  output logic              inc,
  output logic              dec,
  output logic [N_SLOT-1:0] inc_sel,
  output logic [N_SLOT-1:0] dec_sel
);
  logic              req_q;
  logic              was_act;
  logic              act;
  logic [N_SLOT-1:0] cur_sel;
  logic [N_SLOT-1:0] held_sel;

  always_comb begin
    int idx;
    idx = slot_index(int'(dst), int'(outi), N_DST, N_OUT);
    for (int s = 0; s < N_SLOT; s++) cur_sel[s] = (idx == s);
  end

  assign act     = ~mask & (edge_mode ? (req & ~req_q) : req);
  assign inc     = act & ~was_act;
  assign dec     = ~act & was_act;
  assign inc_sel = inc ? cur_sel : '0;
  assign dec_sel = dec ? held_sel : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= 1'b0;
      was_act  <= 1'b0;
      held_sel <= '0;
    end else begin
      req_q   <= req;
      was_act <= act;
      if (inc) held_sel <= cur_sel;
    end
  end
endmodule

// File: rtl/aux_slot_cnt.sv
module aux_slot_cnt #(
  parameter int N_SRC = 8,
  parameter int CW    = $clog2(N_SRC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] inc_col,
  input  logic [N_SRC-1:0] dec_col,
  output logic [CW-1:0]    cnt,
  output logic             irq
);
  logic [CW:0] n_inc, n_dec, sum, nxt;

  always_comb begin
    n_inc = '0;
    n_dec = '0;
    for (int i = 0; i < N_SRC; i++) begin
      n_inc = n_inc + {{CW{1'b0}}, inc_col[i]};
      n_dec = n_dec + {{CW{1'b0}}, dec_col[i]};
    end
    sum = {1'b0, cnt} + n_inc;
    nxt = (n_dec > sum) ? '0 : (sum - n_dec);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      cnt <= nxt[CW-1:0];
      irq <= (nxt != '0);
    end
  end
endmodule

// File: rtl/aux_irq_refcnt.sv
module aux_irq_refcnt #(
  parameter  int N_SRC  = 8,
  parameter  int N_DST  = 3,
  parameter  int N_OUT  = 2,
  localparam int DW     = (N_DST > 1) ? $clog2(N_DST) : 1,
  localparam int OW     = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int N_SLOT = N_DST * N_OUT,
  localparam int CW     = $clog2(N_SRC + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_SRC-1:0]    src_req,
  input  logic [N_SRC-1:0]    src_edge,
  input  logic [N_SRC-1:0]    src_mask,
  input  logic [N_SRC*DW-1:0] src_dst,
  input  logic [N_SRC*OW-1:0] src_out,
  output logic [N_SLOT-1:0]   aux_irq
);
  logic [N_SLOT-1:0] inc_sel [N_SRC];
  logic [N_SLOT-1:0] dec_sel [N_SRC];
  logic [N_SRC-1:0]  inc_col [N_SLOT];
  logic [N_SRC-1:0]  dec_col [N_SLOT];
  logic [N_SRC-1:0]  src_inc, src_dec;
  logic [N_SLOT-1:0] slot_inc, slot_dec;
  logic [N_SLOT*CW-1:0] cnt_flat;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    aux_src_track #(
      .N_DST(N_DST), .N_OUT(N_OUT), .DW(DW), .OW(OW), .N_SLOT(N_SLOT)
    ) u_trk (
      .clk      (clk),
      .rst      (rst),
      .req      (src_req[i]),
      .edge_mode(src_edge[i]),
      .mask     (src_mask[i]),
      .dst      (src_dst[i*DW +: DW]),
      .outi     (src_out[i*OW +: OW]),
      .inc      (src_inc[i]),
      .dec      (src_dec[i]),
      .inc_sel  (inc_sel[i]),
      .dec_sel  (dec_sel[i])
    );
  end

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    for (genvar i = 0; i < N_SRC; i++) begin : g_col
      assign inc_col[s][i] = inc_sel[i][s];
      assign dec_col[s][i] = dec_sel[i][s];
    end
    assign slot_inc[s] = |inc_col[s];
    assign slot_dec[s] = |dec_col[s];
    aux_slot_cnt #(.N_SRC(N_SRC), .CW(CW)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .inc_col(inc_col[s]),
      .dec_col(dec_col[s]),
      .cnt    (cnt_flat[s*CW +: CW]),
      .irq    (aux_irq[s])
    );
  end
endmodule

// File: rtl/aux_refcnt_chk.sv
module aux_refcnt_chk #(
  parameter int N_SRC  = 8,
  parameter int N_SLOT = 6,
  parameter int CW     = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N_SRC-1:0]     src_edge,
  input logic [N_SRC-1:0]     src_inc,
  input logic [N_SRC-1:0]     src_dec,
  input logic [N_SLOT-1:0]    slot_inc,
  input logic [N_SLOT-1:0]    slot_dec,
  input logic [N_SLOT*CW-1:0] cnt_flat,
  input logic [N_SLOT-1:0]    aux_irq
);
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (aux_irq == '0 && cnt_flat == '0));

  for (genvar s = 0; s < N_SLOT; s++) begin : g_s
    a_r10_no_underflow: assert property (@(posedge clk) disable iff (rst)
      (cnt_flat[s*CW +: CW] == '0 && !slot_inc[s]) |-> !slot_dec[s]);
    a_r10_bound: assert property (@(posedge clk) disable iff (rst)
      int'(cnt_flat[s*CW +: CW]) <= N_SRC);
    a_r3_rise_from_zero: assert property (@(posedge clk) disable iff (rst)
      $rose(aux_irq[s]) |-> ($past(cnt_flat[s*CW +: CW]) == '0 && $past(slot_inc[s])));
    a_r4_fall_at_zero: assert property (@(posedge clk) disable iff (rst)
      $fell(aux_irq[s]) |-> (cnt_flat[s*CW +: CW] == '0 && $past(slot_dec[s])));
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
      (!slot_inc[s] && !slot_dec[s]) |=> ($stable(cnt_flat[s*CW +: CW]) && $stable(aux_irq[s])));
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_i
    a_r6_edge_pulse: assert property (@(posedge clk) disable iff (rst)
      (src_edge[i] && src_inc[i]) |=> (src_dec[i] || !src_edge[i]));
  end
endmodule

bind aux_irq_refcnt aux_refcnt_chk #(.N_SRC(N_SRC), .N_SLOT(N_SLOT), .CW(CW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .src_edge(src_edge),
  .src_inc (src_inc),
  .src_dec (src_dec),
  .slot_inc(slot_inc),
  .slot_dec(slot_dec),
  .cnt_flat(cnt_flat),
  .aux_irq (aux_irq)
);

// File: tb/tb_aux_irq_refcnt.sv
`timescale 1ns/1ps
module tb_aux_irq_refcnt;
  localparam int NS = 8, ND = 3, NO = 2, NSL = 6, DW = 2, OW = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [NS-1:0]    req = '0, edg = '0, msk = '0;
  logic [NS*DW-1:0] dst = '0;
  logic [NS*OW-1:0] oix = '0;
  logic [NSL-1:0]   aux;

  aux_irq_refcnt #(.N_SRC(NS), .N_DST(ND), .N_OUT(NO)) dut (
    .clk(clk), .rst(rst), .src_req(req), .src_edge(edg), .src_mask(msk),
    .src_dst(dst), .src_out(oix), .aux_irq(aux)
  );

  int n_cmp = 0, n_bad = 0;
  bit m_rq [NS];
  bit m_was[NS];
  int m_held[NS];
  int m_cnt[NSL];

  function automatic int route_of(int i);
    int d, o;
    d = int'(dst[i*DW +: DW]);
    o = int'(oix[i*OW +: OW]);
    if (d >= ND || o >= NO) return -1;
    return d * NO + o;
  endfunction

  function automatic logic [NSL-1:0] model_aux();
    logic [NSL-1:0] v;
    for (int s = 0; s < NSL; s++) v[s] = (m_cnt[s] != 0);
    return v;
  endfunction

  task automatic model_clock();
    if (rst) begin
      for (int i = 0; i < NS; i++) begin m_rq[i] = 0; m_was[i] = 0; m_held[i] = -1; end
      for (int s = 0; s < NSL; s++) m_cnt[s] = 0;
    end else begin
      for (int i = 0; i < NS; i++) begin
        bit act;
        act = !msk[i] && (edg[i] ? (req[i] && !m_rq[i]) : req[i]);
        if (act && !m_was[i]) begin
          m_held[i] = route_of(i);
          if (m_held[i] >= 0) m_cnt[m_held[i]]++;
        end
        if (!act && m_was[i] && m_held[i] >= 0 && m_cnt[m_held[i]] > 0)
          m_cnt[m_held[i]]--;
        m_rq[i]  = req[i];
        m_was[i] = act;
      end
    end
  endtask

  task automatic check(string tag, logic [NSL-1:0] got, logic [NSL-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: aux_irq=%b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_clock();
    @(negedge clk);
  endtask

  task automatic step_exp(string tag, logic [NSL-1:0] exp);
    step();
    check(tag, aux, exp);
  endtask

  task automatic set_route(int i, int d, int o);
    dst[i*DW +: DW] = DW'(d);
    oix[i*OW +: OW] = OW'(o);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) step();
    check("R1 reset state", aux, '0);
    rst = 1'b0;

    // R3 R4 R5: two level sources share slot 2 (dst 1, out 0)
    set_route(0, 1, 0); set_route(1, 1, 0);
    req[0] = 1; step_exp("R3 first source raises", 6'b000100);
    req[1] = 1; step_exp("R5 second source keeps line", 6'b000100);
    step_exp("R5 held level no change", 6'b000100);
    req[0] = 0; step_exp("R4 one source left", 6'b000100);
    req[1] = 0; step_exp("R4 count back to zero", 6'b000000);

    // R6: edge source on slot 1 (dst 0, out 1)
    set_route(2, 0, 1); edg[2] = 1;
    req[2] = 1; step_exp("R6 edge pulse high", 6'b000010);
    step_exp("R6 edge pulse self-clears", 6'b000000);
    step_exp("R6 held edge request stays quiet", 6'b000000);

    // R7: mask withdraws a level source on slot 5 (dst 2, out 1)
    set_route(3, 2, 1);
    req[3] = 1; step_exp("R7 level raise", 6'b100000);
    msk[3] = 1; step_exp("R7 mask withdraws", 6'b000000);
    msk[3] = 0; step_exp("R7 unmask restores", 6'b100000);
    req[3] = 0; step_exp("R7 release", 6'b000000);
    req[2] = 0; step_exp("R7 edge idle", 6'b000000);
    msk[2] = 1; req[2] = 1; step_exp("R7 masked edge ignored", 6'b000000);
    msk[2] = 0; step_exp("R7 edge not replayed after unmask", 6'b000000);
    req[2] = 0; edg[2] = 0;

    // R8: captured route
    set_route(4, 0, 0);
    req[4] = 1; step_exp("R8 raise on slot 0", 6'b000001);
    set_route(4, 2, 0); step_exp("R8 route change keeps count", 6'b000001);
    req[4] = 0; step_exp("R8 decrement from captured slot", 6'b000000);
    set_route(5, 2, 0);
    req[5] = 1; step_exp("R8 slot 4 counted from zero", 6'b010000);
    req[5] = 0; step_exp("R8 slot 4 back to zero", 6'b000000);

    // R9: out-of-range destination
    set_route(6, 3, 1);
    req[6] = 1; step_exp("R9 invalid route drives nothing", 6'b000000);
    req[6] = 0; step_exp("R9 invalid route release", 6'b000000);

    // R10: all sources on slot 3 in one cycle
    for (int i = 0; i < NS; i++) set_route(i, 1, 1);
    req = '1; step_exp("R10 all sources same cycle", 6'b001000);
    req = 8'b1000_0000; step_exp("R10 seven leave one stays", 6'b001000);
    req = '0; step_exp("R10 last leaves", 6'b000000);

    // R1: reset in the middle of activity
    req[0] = 1; step_exp("R1 pre-reset activity", 6'b001000);
    rst = 1; step_exp("R1 mid-run reset", 6'b000000);
    step(); rst = 0; req = '0;
    step_exp("R1 after reset idle", 6'b000000);

    // R2 R11: random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < NS; i++) begin
        if ($urandom % 4 == 0)  req[i] = ~req[i];
        if ($urandom % 16 == 0) msk[i] = ~msk[i];
        if ($urandom % 48 == 0) edg[i] = ~edg[i];
        if ($urandom % 12 == 0) set_route(i, int'($urandom % 4), int'($urandom % 2));
      end
      rst = ($urandom % 500 == 0);
      step();
      if (rst) begin step(); rst = 0; end
      check("R2/R11 random vs model", aux, model_aux());
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule